// File: doc/BRIEF.md
# Segment Selector Protection Checker

This block decides whether a segment selector, together with the descriptor already fetched for it, may be loaded into a segment register. It handles two checks: a stack-segment load and the code-segment load done by an interrupt return. The rules depend on the current privilege level and on whether the processor runs in 64-bit mode. When more than one fault applies, a fixed priority picks one. The block also reports, through the zero and extended-zero flags, whether the selector was null.

The decision logic itself is combinational. Its result is captured in output registers when the requester pulses the check-enable input, and it appears one cycle later together with a valid strobe. Descriptor fetch is done elsewhere. Check kinds that this block does not implement are reported on a separate output and never raise a fault.

Top module: `seg_prot_chk`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is zero.
- R2: A pulse on `chk_en` makes `res_vld` high in the next cycle only. Without `chk_en`, `fault_oh`, `err_code`, `unimpl`, `zf_o` and `ezf_o` keep their values.
- R3: Check kind 0 (none) gives no fault and leaves `unimpl` low.
- R4: Check kinds 1, 2, 5, 6 and 7 raise `unimpl` and no fault. Kind 3 is the stack check and kind 4 is the interrupt-return check.
- R5: A selector is null when its index (operand bits 15:3) and its table bit (bit 2) are both zero, whatever the requested level in bits 1:0.
- R6: A stack check on a non-null selector gives a stack fault if the descriptor is absent, and no fault if it is present.
- R7: A stack check on a null selector gives a general protection fault, unless all of the following hold:
  - 64-bit mode is on;
  - the current level is not 3;
  - the descriptor is a writable non-system data segment;
  - the descriptor level equals the current level;
  - the requested level equals the current level.
- R8: An interrupt-return check gives a general protection fault if any of the following holds:
  - the selector is null;
  - the requested level is numerically below the current level;
  - the descriptor is not a non-system code segment;
  - the segment is non-conforming and its descriptor level differs from the requested level;
  - the segment is conforming and its descriptor level is above the requested level.
- R9: An interrupt-return check gives a not-present fault only when the descriptor is absent and no general protection cause from R8 applies.
- R10: When a fault is reported, `err_code` equals operand bits 15:0. Otherwise it is zero.
- R11: A check with `flag_upd` high sets `flag_wr` for one cycle, and sets both `zf_o` and `ezf_o` to the null status of the selector. A check with `flag_upd` low leaves `flag_wr` low.
- R12: `fault_oh` is one-hot or zero: bit 0 is general protection, bit 1 is stack fault, bit 2 is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Capture a check result this cycle |
| chk_kind | input | 3 | Check kind code |
| sel_opnd | input | OPND_W | Selector operand; bits 15:0 hold the selector |
| dsc_present | input | 1 | Descriptor present |
| dsc_user | input | 1 | Non-system (code or data) descriptor |
| dsc_code | input | 1 | Code segment (0 = data) |
| dsc_wr | input | 1 | Data segment writable |
| dsc_conf | input | 1 | Code segment conforming |
| dsc_dpl | input | 2 | Descriptor privilege level |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 64-bit mode active |
| flag_upd | input | 1 | Request zero-flag update |
| res_vld | output | 1 | Result valid strobe |
| fault_oh | output | 3 | One-hot fault: GP, stack, not present |
| err_code | output | 16 | Fault error code |
| unimpl | output | 1 | Check kind not implemented |
| flag_wr | output | 1 | Zero flags are being written |
| zf_o | output | 1 | Zero flag value |
| ezf_o | output | 1 | Extended zero flag value |

## Verification
The hardest case to reach is a null selector that passes a stack check. It requires 64-bit mode, a current level other than 3, a writable data descriptor, and descriptor, requested and current levels that all match. Random stimulus almost never lines these up. The bench therefore drives that exact case directly, then breaks one condition at a time. Random runs are biased so that half of the selectors have a zero index and table bit, which covers the null paths of both checks.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [2:0] {
    CK_NONE    = 3'd0,
    CK_CODE    = 3'd1,
    CK_GATE    = 3'd2,
    CK_STACK   = 3'd3,
    CK_IRET    = 3'd4,
    CK_INTCODE = 3'd5
  } chk_kind_e;

  localparam int FLT_GP = 0;
  localparam int FLT_SS = 1;
  localparam int FLT_NP = 2;
  localparam int FLT_N  = 3;
  localparam int PL_W   = 2;
  localparam int SEL_W  = 16;

  typedef struct packed {
    logic            present;
    logic            user;
    logic            code;
    logic            writable;
    logic            conforming;
    logic [PL_W-1:0] dpl;
  } desc_t;
endpackage

// File: rtl/sel_fields.sv
module sel_fields
  import segchk_pkg::*;
#(
  parameter int OPND_W = 32
) (
  input  logic [OPND_W-1:0] sel_opnd,
  output logic              is_null,
  output logic [PL_W-1:0]   rpl,
  output logic [SEL_W-1:0]  sel16
);
  localparam int TI_BIT = 2;

  assign sel16   = sel_opnd[SEL_W-1:0];
  assign rpl     = sel16[PL_W-1:0];
  assign is_null = (sel16[SEL_W-1:TI_BIT] == '0);
endmodule

// File: rtl/stack_rule.sv
module stack_rule
  import segchk_pkg::*;
(
  input  logic            is_null,
  input  desc_t           dsc,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] rpl,
  input  logic            long_mode,
  output logic            gp,
  output logic            ss
);
  logic null_ok;

  always_comb begin
    null_ok = long_mode && (cpl != '1) && dsc.user && !dsc.code &&
              dsc.writable && (dsc.dpl == cpl) && (rpl == cpl);
    gp = is_null && !null_ok;
    ss = !is_null && !dsc.present;
  end
endmodule

// File: rtl/iret_rule.sv
module iret_rule
  import segchk_pkg::*;
(
  input  logic            is_null,
  input  desc_t           dsc,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] rpl,
  output logic            gp,
  output logic            np
);
  logic bad_type, bad_dpl;

  always_comb begin
    bad_type = !(dsc.user && dsc.code);
    bad_dpl  = dsc.conforming ? (dsc.dpl > rpl) : (dsc.dpl != rpl);
    gp = is_null || (rpl < cpl) || bad_type || bad_dpl;
    np = !gp && !dsc.present;
  end
endmodule

// File: rtl/seg_prot_chk.sv
module seg_prot_chk
  import segchk_pkg::*;
#(
  parameter int OPND_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en,
  input  logic [2:0]        chk_kind,
  input  logic [OPND_W-1:0] sel_opnd,
  input  logic              dsc_present,
  input  logic              dsc_user,
  input  logic              dsc_code,
  input  logic              dsc_wr,
  input  logic              dsc_conf,
  input  logic [1:0]        dsc_dpl,
  input  logic [1:0]        cpl,
  input  logic              long_mode,
  input  logic              flag_upd,
  output logic              res_vld,
  output logic [2:0]        fault_oh,
  output logic [15:0]       err_code,
  output logic              unimpl,
  output logic              flag_wr,
  output logic              zf_o,
  output logic              ezf_o
);
  desc_t            dsc;
  logic             is_null;
  logic [PL_W-1:0]  rpl;
  logic [SEL_W-1:0] sel16;
  logic             st_gp, st_ss, ir_gp, ir_np;
  logic [FLT_N-1:0] flt_nxt;
  logic             unimpl_nxt;
  chk_kind_e        kind;

  assign dsc  = '{present: dsc_present, user: dsc_user, code: dsc_code,
                  writable: dsc_wr, conforming: dsc_conf, dpl: dsc_dpl};
  assign kind = chk_kind_e'(chk_kind);

  sel_fields #(.OPND_W(OPND_W)) u_sel (
    .sel_opnd(sel_opnd), .is_null(is_null), .rpl(rpl), .sel16(sel16)
  );

  stack_rule u_stack (
    .is_null(is_null), .dsc(dsc), .cpl(cpl), .rpl(rpl),
    .long_mode(long_mode), .gp(st_gp), .ss(st_ss)
  );

  iret_rule u_iret (
    .is_null(is_null), .dsc(dsc), .cpl(cpl), .rpl(rpl),
    .gp(ir_gp), .np(ir_np)
  );

  always_comb begin
    flt_nxt    = '0;
    unimpl_nxt = 1'b0;
    case (kind)
      CK_NONE:  ;
      CK_STACK: begin
        flt_nxt[FLT_GP] = st_gp;
        flt_nxt[FLT_SS] = !st_gp && st_ss;
      end
      CK_IRET: begin
        flt_nxt[FLT_GP] = ir_gp;
        flt_nxt[FLT_NP] = ir_np;
      end
      default: unimpl_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      fault_oh <= '0;
      err_code <= '0;
      unimpl   <= 1'b0;
      flag_wr  <= 1'b0;
      zf_o     <= 1'b0;
      ezf_o    <= 1'b0;
    end else begin
      res_vld <= chk_en;
      flag_wr <= chk_en && flag_upd;
      if (chk_en) begin
        fault_oh <= flt_nxt;
        err_code <= (flt_nxt != '0) ? sel16 : '0;
        unimpl   <= unimpl_nxt;
        if (flag_upd) begin
          zf_o  <= is_null;
          ezf_o <= is_null;
        end
      end
    end
  end

  // R12
  fault_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_oh));

  // R2
  vld_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> !res_vld && $stable(fault_oh) && $stable(err_code));

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_oh == '0) |-> (err_code == '0));

  // R4
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    unimpl |-> (fault_oh == '0));

  // R9
  np_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_en && chk_kind != 3'd4) |=> !fault_oh[FLT_NP]);

  // R6
  ss_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_en && chk_kind != 3'd3) |=> !fault_oh[FLT_SS]);
endmodule

// File: tb/sim_seg_prot_chk.sv
module sim_seg_prot_chk;
  logic clk = 0, rst = 1;
  logic chk_en = 0, dsc_present = 0, dsc_user = 0, dsc_code = 0, dsc_wr = 0;
  logic dsc_conf = 0, long_mode = 0, flag_upd = 0;
  logic [2:0] chk_kind = 0;
  logic [31:0] sel_opnd = 0;
  logic [1:0] dsc_dpl = 0, cpl = 0;
  logic res_vld, unimpl, flag_wr, zf_o, ezf_o;
  logic [2:0] fault_oh;
  logic [15:0] err_code;

  int checks = 0, errors = 0, cyc = 0;

  // expected registered state
  logic e_vld = 0, e_unimpl = 0, e_fwr = 0, e_zf = 0, e_ezf = 0;
  logic [2:0] e_flt = 0;
  logic [15:0] e_err = 0;

  always #5 clk = ~clk;

  seg_prot_chk u0 (.*);

  function automatic void model(output logic [2:0] flt, output logic un,
                                output logic nul);
    int idx, ti, rq, cp, dp;
    int reasons;
    idx = int'(sel_opnd[15:3]); ti = int'(sel_opnd[2]);
    rq = int'(sel_opnd[1:0]); cp = int'(cpl); dp = int'(dsc_dpl);
    nul = (idx == 0 && ti == 0);
    flt = 3'b000; un = 0;
    if (chk_kind == 3) begin
      if (nul) begin
        if (!(long_mode && cp != 3 && dsc_user && !dsc_code && dsc_wr &&
              dp == cp && rq == cp)) flt = 3'b001;
      end else if (!dsc_present) flt = 3'b010;
    end else if (chk_kind == 4) begin
      reasons = 0;
      if (nul) reasons++;
      if (rq < cp) reasons++;
      if (!dsc_user || !dsc_code) reasons++;
      if (!dsc_conf && dp != rq) reasons++;
      if (dsc_conf && dp > rq) reasons++;
      if (reasons > 0) flt = 3'b001;
      else if (!dsc_present) flt = 3'b100;
    end else if (chk_kind != 0) un = 1;
  endfunction

  always @(posedge clk) begin
    logic [2:0] f; logic u, n;
    cyc <= cyc + 1;
    if (rst) begin
      e_vld <= 0; e_flt <= 0; e_err <= 0; e_unimpl <= 0;
      e_fwr <= 0; e_zf <= 0; e_ezf <= 0;
    end else begin
      model(f, u, n);
      e_vld <= chk_en;
      e_fwr <= chk_en && flag_upd;
      if (chk_en) begin
        e_flt <= f; e_unimpl <= u;
        e_err <= (f != 0) ? sel_opnd[15:0] : 16'h0;
        if (flag_upd) begin e_zf <= n; e_ezf <= n; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    chk("R2 res_vld", res_vld, e_vld);
    chk("R6/R7/R8/R9/R12 fault_oh", fault_oh, e_flt);
    chk("R10 err_code", err_code, e_err);
    chk("R3/R4 unimpl", unimpl, e_unimpl);
    chk("R11 flag_wr", flag_wr, e_fwr);
    chk("R11/R5 zf", {zf_o, ezf_o}, {e_zf, e_ezf});
  end

  task automatic drive(input logic [2:0] k, input logic [15:0] s,
                       input logic p, input logic u, input logic c,
                       input logic w, input logic cf, input logic [1:0] d,
                       input logic [1:0] cp, input logic lm, input logic fu);
    @(negedge clk);
    chk_en = 1; chk_kind = k; sel_opnd = {16'hA5A5, s};
    dsc_present = p; dsc_user = u; dsc_code = c; dsc_wr = w; dsc_conf = cf;
    dsc_dpl = d; cpl = cp; long_mode = lm; flag_upd = fu;
    @(negedge clk);
    chk_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero out of reset
    chk("R1 reset", {res_vld, fault_oh, err_code, unimpl, flag_wr, zf_o, ezf_o}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {res_vld, fault_oh, err_code, unimpl}, 0);
    // R7 passing null stack load, then each condition broken
    drive(3, 16'h0002, 1, 1, 0, 1, 0, 2, 2, 1, 1);
    drive(3, 16'h0002, 1, 1, 0, 1, 0, 2, 2, 0, 1);
    drive(3, 16'h0003, 1, 1, 0, 1, 0, 3, 3, 1, 1);
    drive(3, 16'h0002, 1, 1, 0, 0, 0, 2, 2, 1, 1);
    drive(3, 16'h0001, 1, 1, 0, 1, 0, 2, 2, 1, 1);
    // R5 RPL does not affect null; R6 absent non-null
    drive(3, 16'h0008, 0, 1, 0, 1, 0, 0, 0, 0, 1);
    drive(3, 16'h0004, 1, 1, 0, 1, 0, 0, 0, 0, 1);
    // R8/R9 iret cases
    drive(4, 16'h0013, 0, 1, 1, 0, 0, 3, 1, 0, 0);
    drive(4, 16'h0011, 0, 1, 1, 0, 0, 3, 2, 0, 0);
    drive(4, 16'h0012, 0, 1, 1, 0, 1, 3, 0, 0, 0);
    drive(4, 16'h0012, 1, 1, 1, 0, 1, 1, 0, 0, 0);
    drive(4, 16'h0003, 0, 1, 1, 0, 0, 3, 0, 0, 1);
    // R3/R4 other kinds
    for (int k = 0; k < 8; k++) drive(k[2:0], 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // random, null-biased
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      chk_en = ($urandom % 4) != 0;
      chk_kind = ($urandom % 2) ? 3'(3 + $urandom % 2) : 3'($urandom);
      sel_opnd = $urandom;
      if ($urandom % 2) sel_opnd[15:2] = 0;
      {dsc_present, dsc_user, dsc_code, dsc_wr, dsc_conf, long_mode, flag_upd} = 7'($urandom);
      dsc_dpl = 2'($urandom); cpl = 2'($urandom);
    end
    @(negedge clk); chk_en = 0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule